// File: doc/BRIEF.md
# Socket Buffer Allocator and Address Translator

This block shares one 8 KB transmit memory and one 8 KB receive memory among four sockets. Two 8-bit configuration words, one per direction, give each socket a 2-bit size code. From these the block builds a table of window sizes, wrap masks and base addresses, packing the windows back to back from the region start. It stops granting space once the sizes already handed to lower-numbered sockets reach the 8 KB budget.

The block also turns a request into a stream of physical byte addresses. A request names a socket, a direction, a free-running 16-bit socket pointer and a byte length. Each address is the socket base plus the pointer masked to the window. When the stream runs past the top of the window it restarts at the window base. Addresses leave one per cycle on a valid/ready handshake, and a one-cycle done pulse follows the last one. A request aimed at a socket that received no space is refused with a one-cycle error pulse and no addresses. The memory array itself sits outside this block.

Top module: `sock_buf_xlate`

## Requirements
- R1: In each configuration word, socket s takes bits [2s+1:2s]. Code 0 means 1 KB, 1 means 2 KB, 2 means 4 KB and 3 means 8 KB. The wrap mask is the granted size minus one.
- R2: Socket 0's window starts at the region base: 0x4000 for transmit and 0x6000 for receive by default. Each later socket's base is the previous socket's base plus that socket's granted size.
- R3: Sockets are granted in order 0 to 3. A socket gets its coded size only if the sizes already granted to lower sockets total less than 8192 bytes; otherwise it gets 0.
- R4: The first address of a request is base + (pointer AND mask). Addresses are offered one per cycle on addr_valid_o/addr_ready_i, and an offered address holds stable until it is accepted.
- R5: Each further address uses the next pointer value, masked again. A stream that passes the top of the window continues at the window base. A pointer near 0xFFFF wraps the same way.
- R6: done_o pulses for exactly one cycle, in the cycle after the last address is accepted. A request of length 0 to a socket with space gives done_o in the cycle after acceptance and no addresses.
- R7: A request to a socket whose granted size is 0 gives err_o for one cycle after acceptance. It emits no addresses and no done_o pulse, whatever its length.
- R8: Transmit (req_dir_i = 0, cfg_sel_i = 0) and receive (req_dir_i = 1, cfg_sel_i = 1) have independent configuration words, sizes, masks and bases.
- R9: Both configuration words reset to 0x55. req_ready_o is low in the cycle of a configuration write and in the cycle after it, and in the first cycle after reset release, while the table is rebuilt.
- R10: Only one request is handled at a time. req_ready_o stays low while addresses are pending and in a cycle where done_o or err_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_sel_i | input | 1 | Configuration word to write: 0 transmit, 1 receive |
| cfg_data_i | input | 8 | Four 2-bit size codes |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_sock_i | input | 2 | Socket number |
| req_dir_i | input | 1 | Direction: 0 transmit, 1 receive |
| req_ptr_i | input | 16 | Free-running socket pointer |
| req_len_i | input | 16 | Transfer length in bytes |
| addr_valid_o | output | 1 | Physical address valid |
| addr_ready_i | input | 1 | Physical address accepted |
| addr_o | output | 16 | Physical byte address |
| done_o | output | 1 | One-cycle pulse after the last address |
| err_o | output | 1 | One-cycle pulse for a request to a socket with no space |

## Verification
The bench tests the budget cut-off in both of its forms. In one, an 8 KB socket 0 starves sockets 1 to 3; a design that granted them anyway would emit addresses where an error is expected. In the other, socket 3 still gets 8 KB because only 7 KB sat below it; a design that checked the total including the socket's own size would refuse it. Streams that cross the window top, and pointers that roll past 0xFFFF, expose a design that adds the length without masking or wraps with the wrong mask: it would walk into the neighbouring socket's window. Zero-length requests, requests to zero-size sockets, stalls on addr_ready_i and requests issued right after a configuration write catch missing or doubled pulses, a moving address during a stall, and requests accepted against a stale table.

// File: rtl/sock_buf_pkg.sv
package sock_buf_pkg;
  typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;

  // window size in bytes for a size code
  function automatic int unsigned code_bytes(input int unsigned code, input int unsigned min_log2);
    return 32'd1 << (min_log2 + code);
  endfunction
endpackage

// File: rtl/sock_buf_alloc.sv
module sock_buf_alloc
  import sock_buf_pkg::*;
#(
  parameter int unsigned NUM_SOCK = 4,
  parameter int unsigned CODE_W   = 2,
  parameter int unsigned MIN_LOG2 = 10,
  parameter int unsigned BUDGET   = 8192,
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REGION_BASE = '0
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NUM_SOCK*CODE_W-1:0]         cfg_i,
  output logic [NUM_SOCK-1:0][ADDR_W-1:0]    size_o,
  output logic [NUM_SOCK-1:0][ADDR_W-1:0]    base_o,
  output logic [NUM_SOCK-1:0][ADDR_W-1:0]    mask_o
);
  localparam int unsigned SUM_W = ADDR_W + 2;

  logic [NUM_SOCK:0][SUM_W-1:0] cum;
  assign cum[0] = '0;

  for (genvar i = 0; i < NUM_SOCK; i++) begin : g_sock
    logic [CODE_W-1:0] code;
    logic [SUM_W-1:0]  raw;
    logic [SUM_W-1:0]  grant;
    logic [ADDR_W-1:0] size_q, base_q, mask_q;

    assign code  = cfg_i[i*CODE_W +: CODE_W];
    assign raw   = SUM_W'(code_bytes(32'(code), MIN_LOG2));
    // budget is checked against lower sockets only
    assign grant = (cum[i] < SUM_W'(BUDGET)) ? raw : '0;
    assign cum[i+1] = cum[i] + grant;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        size_q <= '0;
        base_q <= REGION_BASE;
        mask_q <= '0;
      end else begin
        size_q <= ADDR_W'(grant);
        base_q <= REGION_BASE + ADDR_W'(cum[i]);
        mask_q <= ADDR_W'(grant - SUM_W'(1));
      end
    end

    assign size_o[i] = size_q;
    assign base_o[i] = base_q;
    assign mask_o[i] = mask_q;
  end
endmodule

// File: rtl/sock_buf_walk.sv
module sock_buf_walk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] size_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              addr_ready_i,
  output logic              busy_o,
  output logic              addr_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic              err_o
);
  logic              run_q, done_q, err_q;
  logic [ADDR_W-1:0] base_q, mask_q, off_q;
  logic [LEN_W-1:0]  rem_q;
  logic              step;

  assign step = run_q && addr_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      base_q <= '0;
      mask_q <= '0;
      off_q  <= '0;
      rem_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (start_i) begin
        if (size_i == '0) begin
          err_q <= 1'b1;
        end else if (len_i == '0) begin
          done_q <= 1'b1;
        end else begin
          run_q  <= 1'b1;
          base_q <= base_i;
          mask_q <= mask_i;
          off_q  <= ptr_i & mask_i;
          rem_q  <= len_i;
        end
      end else if (step) begin
        off_q <= (off_q + ADDR_W'(1)) & mask_q;
        rem_q <= rem_q - LEN_W'(1);
        if (rem_q == LEN_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o       = run_q;
  assign addr_valid_o = run_q;
  assign addr_o       = base_q + off_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
endmodule

// File: rtl/sock_buf_xlate.sv
module sock_buf_xlate
  import sock_buf_pkg::*;
#(
  parameter int unsigned NUM_SOCK = 4,
  parameter int unsigned CODE_W   = 2,
  parameter int unsigned MIN_LOG2 = 10,
  parameter int unsigned BUDGET   = 8192,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned PTR_W    = 16,
  parameter int unsigned LEN_W    = 16,
  parameter logic [ADDR_W-1:0] TX_BASE = 16'h4000,
  parameter logic [ADDR_W-1:0] RX_BASE = 16'h6000,
  parameter logic [NUM_SOCK*CODE_W-1:0] CFG_RST = 8'h55
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cfg_we_i,
  input  logic                        cfg_sel_i,
  input  logic [NUM_SOCK*CODE_W-1:0]  cfg_data_i,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [$clog2(NUM_SOCK)-1:0] req_sock_i,
  input  logic                        req_dir_i,
  input  logic [PTR_W-1:0]            req_ptr_i,
  input  logic [LEN_W-1:0]            req_len_i,
  output logic                        addr_valid_o,
  input  logic                        addr_ready_i,
  output logic [ADDR_W-1:0]           addr_o,
  output logic                        done_o,
  output logic                        err_o
);
  localparam int unsigned CFG_W = NUM_SOCK * CODE_W;

  logic [1:0][CFG_W-1:0] cfg_q;
  logic                  stale_q;
  logic [1:0][NUM_SOCK-1:0][ADDR_W-1:0] size_t, base_t, mask_t;
  logic                  dir_idx, start, busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= {2{CFG_RST}};
      stale_q <= 1'b1;
    end else begin
      if (cfg_we_i) cfg_q[cfg_sel_i] <= cfg_data_i;
      stale_q <= cfg_we_i; // table reloads on the following edge
    end
  end

  for (genvar d = 0; d < 2; d++) begin : g_dir
    sock_buf_alloc #(
      .NUM_SOCK   (NUM_SOCK),
      .CODE_W     (CODE_W),
      .MIN_LOG2   (MIN_LOG2),
      .BUDGET     (BUDGET),
      .ADDR_W     (ADDR_W),
      .REGION_BASE((d == 0) ? TX_BASE : RX_BASE)
    ) u_alloc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cfg_i  (cfg_q[d]),
      .size_o (size_t[d]),
      .base_o (base_t[d]),
      .mask_o (mask_t[d])
    );
  end

  assign dir_idx     = (req_dir_i == DIR_RX);
  assign req_ready_o = !busy && !done_o && !err_o && !stale_q && !cfg_we_i;
  assign start       = req_valid_i && req_ready_o;

  sock_buf_walk #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W)
  ) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .size_i      (size_t[dir_idx][req_sock_i]),
    .base_i      (base_t[dir_idx][req_sock_i]),
    .mask_i      (mask_t[dir_idx][req_sock_i]),
    .ptr_i       (ADDR_W'(req_ptr_i)),
    .len_i       (req_len_i),
    .addr_ready_i(addr_ready_i),
    .busy_o      (busy),
    .addr_valid_o(addr_valid_o),
    .addr_o      (addr_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );
endmodule

// File: rtl/sock_buf_xlate_chk.sv
module sock_buf_xlate_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              addr_valid_o,
  input logic              addr_ready_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o,
  input logic              err_o
);
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && !addr_ready_i) |=> (addr_valid_o && $stable(addr_o))); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(req_valid_i && req_ready_o) || $past(addr_valid_o && addr_ready_i))); // R6
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_valid_i && req_ready_o)); // R7
  AST_ERR_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!addr_valid_o && !done_o)); // R7
  AST_CFG_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !req_ready_o); // R9
  AST_ONE_AT_A_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o || done_o || err_o) |-> !req_ready_o); // R10
endmodule

bind sock_buf_xlate sock_buf_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .addr_valid_o(addr_valid_o),
  .addr_ready_i(addr_ready_i),
  .addr_o      (addr_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/tb_sock_buf_xlate.sv
`timescale 1ns/1ps
module tb_sock_buf_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_data = '0;
  logic        req_valid = 1'b0, req_dir = 1'b0;
  logic [1:0]  req_sock = '0;
  logic [15:0] req_ptr = '0, req_len = '0;
  logic        addr_ready = 1'b1;
  logic        req_ready, addr_valid, done, err;
  logic [15:0] addr;

  int total = 0, fails = 0;
  bit finished = 0;
  logic [15:0] seen [0:63];
  logic [7:0]  cur_tx = 8'h55, cur_rx = 8'h55;

  always #4 clk = ~clk;

  sock_buf_xlate dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_sock_i(req_sock),
    .req_dir_i(req_dir), .req_ptr_i(req_ptr), .req_len_i(req_len),
    .addr_valid_o(addr_valid), .addr_ready_i(addr_ready), .addr_o(addr),
    .done_o(done), .err_o(err)
  );

  typedef struct packed {
    logic [7:0]  tx;
    logic [7:0]  rx;
    logic        dir;
    logic [1:0]  sock;
    logic [15:0] ptr;
    logic [15:0] len;
    logic [15:0] first;
    logic        err;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h55, 8'h55, 1'b0, 2'd2, 16'h0010, 16'd4, 16'h5010, 1'b0},
    '{8'h55, 8'h55, 1'b1, 2'd1, 16'h17FE, 16'd4, 16'h6FFE, 1'b0},
    '{8'h03, 8'h55, 1'b0, 2'd1, 16'h0000, 16'd4, 16'h0000, 1'b1},
    '{8'hC0, 8'h55, 1'b0, 2'd3, 16'hFFFF, 16'd2, 16'h6BFF, 1'b0},
    '{8'h55, 8'h1B, 1'b1, 2'd0, 16'h2345, 16'd3, 16'h6345, 1'b0},
    '{8'h55, 8'hE4, 1'b1, 2'd3, 16'h0400, 16'd1, 16'h8000, 1'b0},
    '{8'h55, 8'hE4, 1'b1, 2'd2, 16'h1FFF, 16'd2, 16'h7BFF, 1'b0},
    '{8'hC0, 8'hE4, 1'b0, 2'd0, 16'h0801, 16'd1, 16'h4001, 1'b0}
  };

  function automatic string vec_tag(input int v);
    case (v)
      0: return "R1 R2 R4";
      1: return "R5 R8";
      2: return "R3 R7";
      3: return "R3 R5";
      4: return "R3 R1";
      5: return "R2 R3";
      6: return "R5 R2";
      default: return "R8";
    endcase
  endfunction

  // independent model of the grant rule
  function automatic void m_alloc(input logic [7:0] cfg, input int s, output int sz, output int off);
    int sum = 0;
    int g;
    sz = 0;
    off = 0;
    for (int k = 0; k < 4; k++) begin
      g = (sum < 8192) ? (1024 << int'(cfg[2*k +: 2])) : 0;
      if (k == s) begin sz = g; off = sum; end
      sum += g;
    end
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    if (sel) cur_rx = d; else cur_tx = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input logic dir, input logic [1:0] s, input logic [15:0] p, input logic [15:0] l);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_dir = dir; req_sock = s; req_ptr = p; req_len = l; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic collect(output int n, output bit de, output bit ee);
    n = 0; de = 0; ee = 0;
    for (int c = 0; c < 300; c++) begin
      if (done) begin de = 1; break; end
      if (err) begin ee = 1; break; end
      if (addr_valid && addr_ready) begin
        if (n < 64) seen[n] = addr;
        n++;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_stream(input logic dir, input logic [1:0] s, input logic [15:0] p, input int n, input string tag);
    int sz, off, base;
    m_alloc(dir ? cur_rx : cur_tx, int'(s), sz, off);
    base = (dir ? 32'h6000 : 32'h4000) + off;
    for (int i = 0; i < n && i < 64; i++) begin
      int e;
      e = (base + ((int'(p) + i) & (sz - 1))) & 32'hFFFF;
      chk(seen[i] == 16'(e), tag, int'(seen[i]), e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int n;
    bit de, ee;

    // reset state
    repeat (3) @(negedge clk);
    chk(!addr_valid && !done && !err, "R4 R6 R7 reset outputs idle", {addr_valid, done, err}, 0);
    rst_n = 1'b1;
    chk(req_ready == 1'b0, "R9 ready low in first cycle after reset", req_ready, 0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready after table load", req_ready, 1);

    // reset configuration 0x55: socket 3 at base + 6 KB
    issue(1'b0, 2'd3, 16'h0000, 16'd1);
    collect(n, de, ee);
    chk(n == 1 && seen[0] == 16'h5800, "R9 reset tx config", int'(seen[0]), 32'h5800);
    issue(1'b1, 2'd3, 16'h0000, 16'd1);
    collect(n, de, ee);
    chk(n == 1 && seen[0] == 16'h7800, "R9 reset rx config", int'(seen[0]), 32'h7800);

    // table-driven vectors
    for (int v = 0; v < 8; v++) begin
      cfg_wr(1'b0, VECS[v].tx);
      cfg_wr(1'b1, VECS[v].rx);
      issue(VECS[v].dir, VECS[v].sock, VECS[v].ptr, VECS[v].len);
      collect(n, de, ee);
      chk(ee == VECS[v].err, {vec_tag(v), " error flag"}, ee, VECS[v].err);
      if (VECS[v].err) begin
        chk(n == 0 && !de, {vec_tag(v), " no addresses on error"}, n, 0);
      end else begin
        chk(n == int'(VECS[v].len) && de, {vec_tag(v), " address count"}, n, VECS[v].len);
        chk(seen[0] == VECS[v].first, {vec_tag(v), " first address"}, int'(seen[0]), VECS[v].first);
        check_stream(VECS[v].dir, VECS[v].sock, VECS[v].ptr, n, {vec_tag(v), " address sequence"});
      end
    end

    // configuration write blocks requests for two cycles
    cfg_wr(1'b0, 8'h00);
    chk(req_ready == 1'b0, "R9 ready low after config write", req_ready, 0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready returns", req_ready, 1);

    // pointer rollover with back-pressure, 1 KB socket 0
    addr_ready = 1'b0;
    issue(1'b0, 2'd0, 16'hFFFE, 16'd4);
    chk(addr_valid && addr == 16'h43FE, "R4 first address under stall", int'(addr), 32'h43FE);
    chk(req_ready == 1'b0, "R10 ready low while busy", req_ready, 0);
    repeat (3) @(negedge clk);
    chk(addr_valid && addr == 16'h43FE, "R4 address held during stall", int'(addr), 32'h43FE);
    addr_ready = 1'b1;
    collect(n, de, ee);
    chk(n == 4 && de, "R6 count then done", n, 4);
    chk(seen[1] == 16'h43FF, "R5 window top", int'(seen[1]), 32'h43FF);
    chk(seen[2] == 16'h4000, "R5 wrap to base", int'(seen[2]), 32'h4000);
    chk(seen[3] == 16'h4001, "R5 after wrap", int'(seen[3]), 32'h4001);
    chk(req_ready == 1'b0, "R10 ready low during done", req_ready, 0);
    @(negedge clk);
    chk(done == 1'b0, "R6 done lasts one cycle", done, 0);

    // zero length
    issue(1'b0, 2'd1, 16'h0123, 16'd0);
    collect(n, de, ee);
    chk(n == 0 && de && !ee, "R6 zero length gives done only", n, 0);

    // zero-size socket with zero length still errors
    cfg_wr(1'b0, 8'h03);
    issue(1'b0, 2'd2, 16'h0000, 16'd0);
    collect(n, de, ee);
    chk(ee && !de && n == 0, "R7 zero-size socket refused", {ee, de}, 2);
    @(negedge clk);
    chk(err == 1'b0, "R7 err lasts one cycle", err, 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule